// File: doc/BRIEF.md
# ABR Egress Resource-Management Cell Processor

This block sits on the egress side of a switch port, between the fabric and the output scheduler, and handles cells that belong to Available Bit Rate connections. Every cell arrives with a type code (user data, forward RM or backward RM), a connection number and its congestion, no-increase and EFCI header bits. The block passes on a cell descriptor per output slot to the scheduler that follows it. That scheduler, which is outside this block, serves constant and variable rate traffic first and gives ABR traffic its minimum rate plus any idle slots.

A mode input selects how the node behaves. In transit mode the node is not a segment boundary. It only marks congestion into the RM cells that pass through. In segment-end mode that marking is off, and the block terminates the upstream control loop and starts a new one downstream. As the terminating end, it turns each forward RM cell back as a backward RM cell. As the originating end, it keeps a current cell rate for each connection, adjusts that rate from incoming backward RM cells, and inserts a forward RM cell after a fixed count of data cells. Congestion comes from an ABR queue-level input, judged against two thresholds with hysteresis, or from an external congestion flag.

Generated cells take precedence over new input. While one is waiting, the block holds `inReady` low, so a turned-around cell leaves before any further data on its connection.

Top module: `abr_rm_egress`

## Requirements
- R1: After reset `outValid` is 0 and `inReady` is 1, and the current cell rate of every connection is `ICR_RATE`.
- R2: The internal congestion flag sets on a clock edge where `abrLevel` > `HI_TH` and clears on one where `abrLevel` < `LO_TH`. Between the thresholds it holds its value. The effective congestion used for marking is this flag OR `extCong`.
- R3: Type codes are: 0 data, 1 forward RM, 2 backward RM, 3 reserved. With `segEnd` = 0, an accepted data or RM cell appears on the outputs one cycle later with the same type and connection. A data cell keeps its EFCI bit and has CI = NI = 0. An RM cell keeps its NI bit and carries CI = input CI OR effective congestion. In this mode `outRate` is 0 and no rate or counter changes.
- R4: With `segEnd` = 1, an accepted forward RM cell produces no output in the next cycle. In the cycle after that, a backward RM cell appears for the same connection. Its CI is input CI OR the effective congestion at acceptance, and its NI is the input NI.
- R5: While a generated cell waits, `inReady` is 0 and the generated cell is emitted on the next edge. Cells offered while `inReady` is 0 are not taken.
- R6: With `segEnd` = 1, an accepted data cell appears one cycle later with EFCI = 0. On every `NRM`-th data cell of a connection, a forward RM cell for that connection follows in the next cycle, with `outRate` set to the connection's current rate and CI = NI = 0.
- R7: With `segEnd` = 1, an accepted backward RM cell produces no output. It changes the connection's rate: CI = 1 subtracts rate >> `RDF_SHIFT`; CI = 0 with NI = 0 adds `PCR_RATE` >> `RIF_SHIFT`; CI = 0 with NI = 1 leaves the rate unchanged.
- R8: The result of every rate update is limited to the range `MCR_RATE`..`PCR_RATE`.
- R9: A reserved type cell, or any input while `inValid` is 0, produces no output and changes no state.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rstN | input | 1 | Asynchronous reset, active low |
| segEnd | input | 1 | 1: segment end point (virtual source and destination), 0: transit marking |
| extCong | input | 1 | External congestion indication |
| abrLevel | input | LEVEL_W | Current ABR queue occupancy |
| inValid | input | 1 | Input cell present |
| inType | input | 2 | Cell type code (see R3) |
| inConn | input | CONN_W | Connection number |
| inCi | input | 1 | Congestion bit of input RM cell |
| inNi | input | 1 | No-increase bit of input RM cell |
| inEfci | input | 1 | EFCI bit of input data cell |
| inReady | output | 1 | Block can take a cell this cycle |
| outValid | output | 1 | Descriptor valid |
| outType | output | 2 | Descriptor cell type |
| outConn | output | CONN_W | Descriptor connection |
| outCi | output | 1 | Descriptor congestion bit |
| outNi | output | 1 | Descriptor no-increase bit |
| outEfci | output | 1 | Descriptor EFCI bit |
| outRate | output | RATE_W | Current rate carried in generated forward RM cells, else 0 |

## Verification
The rate can only be seen through inserted forward RM cells. The clamps are therefore hard to reach: a connection needs a long run of backward RM cells with one bit pattern, followed by a burst of exactly enough data cells to force an insertion. The stimulus drives a connection down to its minimum with repeated CI = 1 cells, checks that NI holds the rate, then climbs to the peak with CI = NI = 0 cells, and inserts data bursts between the runs. A long mixed phase then toggles the mode and queue level while cells arrive on back-to-back cycles. This exercises stalls behind pending generated cells and the congestion hysteresis.

// File: rtl/abr_pkg.sv
package abr_pkg;

  typedef enum logic [1:0] {
    CELL_DATA = 2'd0,
    CELL_FRM  = 2'd1,
    CELL_BRM  = 2'd2,
    CELL_RSVD = 2'd3
  } cell_e;

  // strobes from control to datapath for one cycle
  typedef struct packed {
    logic  emit;
    cell_e emitType;
    logic  emitCi;
    logic  emitNi;
    logic  emitEfci;
    logic  useRate;
    logic  rateUpd;
    logic  updCi;
    logic  updNi;
  } strobe_t;

endpackage

// File: rtl/abr_ctrl.sv
module abr_ctrl
  import abr_pkg::*;
#(
  parameter int CONN_W  = 2,
  parameter int NRM     = 4,
  parameter int LEVEL_W = 8,
  parameter int HI_TH   = 48,
  parameter int LO_TH   = 16
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               segEnd,
  input  logic               extCong,
  input  logic [LEVEL_W-1:0] abrLevel,
  input  logic               inValid,
  input  logic [1:0]         inType,
  input  logic [CONN_W-1:0]  inConn,
  input  logic               inCi,
  input  logic               inNi,
  input  logic               inEfci,
  output logic               inReady,
  output strobe_t            strb,
  output logic [CONN_W-1:0]  emitConn,
  output logic [CONN_W-1:0]  updConn
);

  localparam int NCONN = 1 << CONN_W;
  localparam int CNT_W = $clog2(NRM + 1);
  localparam logic [CNT_W-1:0] CNT_LAST = CNT_W'(NRM - 1);

  logic              congReg;
  logic              congEff;
  logic              accept;
  logic              dataHit;
  logic              wrapHit;
  cell_e             cellType;
  logic              pendValid;
  cell_e             pendType;
  logic [CONN_W-1:0] pendConn;
  logic              pendCi;
  logic              pendNi;
  logic [CNT_W-1:0]  dataCnt [NCONN];

  assign cellType = cell_e'(inType);
  assign inReady  = !pendValid;
  assign accept   = inValid && inReady;
  assign congEff  = congReg || extCong;
  assign dataHit  = accept && segEnd && (cellType == CELL_DATA);
  assign wrapHit  = dataHit && (dataCnt[inConn] == CNT_LAST);
  assign updConn  = inConn;

  // queue congestion with hysteresis
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      congReg <= 1'b0;
    end else if (abrLevel > LEVEL_W'(HI_TH)) begin
      congReg <= 1'b1;
    end else if (abrLevel < LEVEL_W'(LO_TH)) begin
      congReg <= 1'b0;
    end
  end

  // data cell counters per connection for forward RM insertion
  for (genvar g = 0; g < NCONN; g++) begin : g_cnt
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        dataCnt[g] <= '0;
      end else if (dataHit && (inConn == CONN_W'(g))) begin
        dataCnt[g] <= (dataCnt[g] == CNT_LAST) ? '0 : dataCnt[g] + 1'b1;
      end
    end
  end

  // single slot for a generated cell
  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      pendValid <= 1'b0;
      pendType  <= CELL_DATA;
      pendConn  <= '0;
      pendCi    <= 1'b0;
      pendNi    <= 1'b0;
    end else if (pendValid) begin
      pendValid <= 1'b0;
    end else if (accept && segEnd && cellType == CELL_FRM) begin
      pendValid <= 1'b1;
      pendType  <= CELL_BRM;
      pendConn  <= inConn;
      pendCi    <= inCi || congEff;
      pendNi    <= inNi;
    end else if (wrapHit) begin
      pendValid <= 1'b1;
      pendType  <= CELL_FRM;
      pendConn  <= inConn;
      pendCi    <= 1'b0;
      pendNi    <= 1'b0;
    end
  end

  always_comb begin
    strb     = '0;
    emitConn = inConn;
    if (pendValid) begin
      strb.emit     = 1'b1;
      strb.emitType = pendType;
      strb.emitCi   = pendCi;
      strb.emitNi   = pendNi;
      strb.useRate  = (pendType == CELL_FRM);
      emitConn      = pendConn;
    end else if (accept) begin
      unique case (cellType)
        CELL_DATA: begin
          strb.emit     = 1'b1;
          strb.emitType = CELL_DATA;
          strb.emitEfci = segEnd ? 1'b0 : inEfci;
        end
        CELL_FRM, CELL_BRM: begin
          if (!segEnd) begin
            strb.emit     = 1'b1;
            strb.emitType = cellType;
            strb.emitCi   = inCi || congEff;
            strb.emitNi   = inNi;
          end else if (cellType == CELL_BRM) begin
            strb.rateUpd = 1'b1;
            strb.updCi   = inCi;
            strb.updNi   = inNi;
          end
        end
        default: strb = '0;
      endcase
    end
  end

endmodule

// File: rtl/abr_datapath.sv
module abr_datapath
  import abr_pkg::*;
#(
  parameter int CONN_W    = 2,
  parameter int RATE_W    = 16,
  parameter int PCR_RATE  = 4000,
  parameter int MCR_RATE  = 500,
  parameter int ICR_RATE  = 1000,
  parameter int RDF_SHIFT = 4,
  parameter int RIF_SHIFT = 5
) (
  input  logic              clk,
  input  logic              rstN,
  input  strobe_t           strb,
  input  logic [CONN_W-1:0] emitConn,
  input  logic [CONN_W-1:0] updConn,
  output logic              outValid,
  output logic [1:0]        outType,
  output logic [CONN_W-1:0] outConn,
  output logic              outCi,
  output logic              outNi,
  output logic              outEfci,
  output logic [RATE_W-1:0] outRate
);

  localparam int NCONN = 1 << CONN_W;
  localparam logic [RATE_W:0]   PCR_X   = (RATE_W+1)'(PCR_RATE);
  localparam logic [RATE_W:0]   MCR_X   = (RATE_W+1)'(MCR_RATE);
  localparam logic [RATE_W:0]   INC_X   = (RATE_W+1)'(PCR_RATE >> RIF_SHIFT);
  localparam logic [RATE_W-1:0] ICR_X   = RATE_W'(ICR_RATE);

  logic [RATE_W-1:0] ccr [NCONN];
  logic [RATE_W:0]   curX;
  logic [RATE_W:0]   candX;
  logic [RATE_W-1:0] nextRate;

  always_comb begin
    curX = {1'b0, ccr[updConn]};
    if (strb.updCi) begin
      candX = curX - (curX >> RDF_SHIFT);
    end else if (!strb.updNi) begin
      candX = curX + INC_X;
    end else begin
      candX = curX;
    end
    if (candX > PCR_X) begin
      candX = PCR_X;
    end else if (candX < MCR_X) begin
      candX = MCR_X;
    end
    nextRate = candX[RATE_W-1:0];
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      for (int i = 0; i < NCONN; i++) ccr[i] <= ICR_X;
    end else if (strb.rateUpd) begin
      ccr[updConn] <= nextRate;
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      outValid <= 1'b0;
      outType  <= '0;
      outConn  <= '0;
      outCi    <= 1'b0;
      outNi    <= 1'b0;
      outEfci  <= 1'b0;
      outRate  <= '0;
    end else if (strb.emit) begin
      outValid <= 1'b1;
      outType  <= strb.emitType;
      outConn  <= emitConn;
      outCi    <= strb.emitCi;
      outNi    <= strb.emitNi;
      outEfci  <= strb.emitEfci;
      outRate  <= strb.useRate ? ccr[emitConn] : '0;
    end else begin
      outValid <= 1'b0;
      outType  <= '0;
      outConn  <= '0;
      outCi    <= 1'b0;
      outNi    <= 1'b0;
      outEfci  <= 1'b0;
      outRate  <= '0;
    end
  end

endmodule

// File: rtl/abr_rm_egress.sv
module abr_rm_egress
  import abr_pkg::*;
#(
  parameter int CONN_W    = 2,
  parameter int RATE_W    = 16,
  parameter int LEVEL_W   = 8,
  parameter int NRM       = 4,
  parameter int HI_TH     = 48,
  parameter int LO_TH     = 16,
  parameter int PCR_RATE  = 4000,
  parameter int MCR_RATE  = 500,
  parameter int ICR_RATE  = 1000,
  parameter int RDF_SHIFT = 4,
  parameter int RIF_SHIFT = 5
) (
  input  logic               clk,
  input  logic               rstN,
  input  logic               segEnd,
  input  logic               extCong,
  input  logic [LEVEL_W-1:0] abrLevel,
  input  logic               inValid,
  input  logic [1:0]         inType,
  input  logic [CONN_W-1:0]  inConn,
  input  logic               inCi,
  input  logic               inNi,
  input  logic               inEfci,
  output logic               inReady,
  output logic               outValid,
  output logic [1:0]         outType,
  output logic [CONN_W-1:0]  outConn,
  output logic               outCi,
  output logic               outNi,
  output logic               outEfci,
  output logic [RATE_W-1:0]  outRate
);

  strobe_t           strb;
  logic [CONN_W-1:0] emitConn;
  logic [CONN_W-1:0] updConn;

  abr_ctrl #(
    .CONN_W(CONN_W), .NRM(NRM), .LEVEL_W(LEVEL_W), .HI_TH(HI_TH), .LO_TH(LO_TH)
  ) i_ctrl (
    .clk(clk), .rstN(rstN), .segEnd(segEnd), .extCong(extCong),
    .abrLevel(abrLevel), .inValid(inValid), .inType(inType), .inConn(inConn),
    .inCi(inCi), .inNi(inNi), .inEfci(inEfci), .inReady(inReady),
    .strb(strb), .emitConn(emitConn), .updConn(updConn)
  );

  abr_datapath #(
    .CONN_W(CONN_W), .RATE_W(RATE_W), .PCR_RATE(PCR_RATE), .MCR_RATE(MCR_RATE),
    .ICR_RATE(ICR_RATE), .RDF_SHIFT(RDF_SHIFT), .RIF_SHIFT(RIF_SHIFT)
  ) i_dp (
    .clk(clk), .rstN(rstN), .strb(strb), .emitConn(emitConn), .updConn(updConn),
    .outValid(outValid), .outType(outType), .outConn(outConn), .outCi(outCi),
    .outNi(outNi), .outEfci(outEfci), .outRate(outRate)
  );

endmodule

// File: rtl/abr_rm_egress_chk.sv
module abr_rm_egress_chk #(
  parameter int CONN_W   = 2,
  parameter int RATE_W   = 16,
  parameter int PCR_RATE = 4000,
  parameter int MCR_RATE = 500
) (
  input logic              clk,
  input logic              rstN,
  input logic              segEnd,
  input logic              inValid,
  input logic [1:0]        inType,
  input logic [CONN_W-1:0] inConn,
  input logic              inReady,
  input logic              outValid,
  input logic [1:0]        outType,
  input logic [CONN_W-1:0] outConn,
  input logic              outEfci,
  input logic [RATE_W-1:0] outRate
);

  logic take;
  assign take = inValid && inReady;

  p_transit_fwd_r3: assert property (@(posedge clk) disable iff (!rstN)
    (take && !segEnd && inType != 2'd3) |=>
      (outValid && outType == $past(inType) && outConn == $past(inConn)));

  p_turnaround_r4: assert property (@(posedge clk) disable iff (!rstN)
    (take && segEnd && inType == 2'd1) |=>
      (!outValid && !inReady) ##1 (outValid && outType == 2'd2 && outConn == $past(inConn, 2)));

  p_stall_emits_r5: assert property (@(posedge clk) disable iff (!rstN)
    !inReady |=> outValid);

  p_data_efci_r6: assert property (@(posedge clk) disable iff (!rstN)
    (take && segEnd && inType == 2'd0) |=> (outValid && outType == 2'd0 && !outEfci));

  p_brm_consumed_r7: assert property (@(posedge clk) disable iff (!rstN)
    (take && segEnd && inType == 2'd2) |=> (!outValid && inReady));

  p_rate_band_r8: assert property (@(posedge clk) disable iff (!rstN)
    (outValid && outType == 2'd1 && outRate != '0) |->
      (outRate >= RATE_W'(MCR_RATE) && outRate <= RATE_W'(PCR_RATE)));

  p_rsvd_ignored_r9: assert property (@(posedge clk) disable iff (!rstN)
    (take && inType == 2'd3) |=> (!outValid && inReady));

endmodule

bind abr_rm_egress abr_rm_egress_chk #(
  .CONN_W(CONN_W), .RATE_W(RATE_W), .PCR_RATE(PCR_RATE), .MCR_RATE(MCR_RATE)
) i_chk (
  .clk(clk), .rstN(rstN), .segEnd(segEnd), .inValid(inValid), .inType(inType),
  .inConn(inConn), .inReady(inReady), .outValid(outValid), .outType(outType),
  .outConn(outConn), .outEfci(outEfci), .outRate(outRate)
);

// File: tb/test_abr_rm_egress.sv
module test_abr_rm_egress;

  localparam int CW = 2, RW = 16, LW = 8, NRM = 4, HI = 48, LO = 16;
  localparam int PCR = 4000, MCR = 500, ICR = 1000, RDF = 4, RIF = 5;
  localparam int NC = 1 << CW;

  logic clk = 1'b0, rstN = 1'b0, segEnd = 1'b0, extCong = 1'b0;
  logic [LW-1:0] abrLevel = '0;
  logic inValid = 1'b0, inCi = 1'b0, inNi = 1'b0, inEfci = 1'b0;
  logic [1:0] inType = '0;
  logic [CW-1:0] inConn = '0;
  logic inReady, outValid, outCi, outNi, outEfci;
  logic [1:0] outType;
  logic [CW-1:0] outConn;
  logic [RW-1:0] outRate;

  always #2.5 clk = ~clk;

  abr_rm_egress #(
    .CONN_W(CW), .RATE_W(RW), .LEVEL_W(LW), .NRM(NRM), .HI_TH(HI), .LO_TH(LO),
    .PCR_RATE(PCR), .MCR_RATE(MCR), .ICR_RATE(ICR), .RDF_SHIFT(RDF), .RIF_SHIFT(RIF)
  ) i_abr_rm_egress (.*);

  int compared = 0, mismatched = 0;
  bit finished = 0;

  // behavioural reference state
  int mCcr[NC];
  int mCnt[NC];
  bit mPend; int mPType; int mPConn; bit mPCi; bit mPNi;
  bit mCong;
  logic [23:0] expVec;
  string expTag;

  function automatic logic [23:0] pack(bit v, int t, int c, bit ci, bit ni, bit ef, int r);
    return {v, 2'(t), 2'(c), ci, ni, ef, 16'(r)};
  endfunction

  task automatic modelReset();
    for (int i = 0; i < NC; i++) begin mCcr[i] = ICR; mCnt[i] = 0; end
    mPend = 0; mPType = 0; mPConn = 0; mPCi = 0; mPNi = 0; mCong = 0;
    expVec = '0; expTag = "R1";
  endtask

  function automatic string rateTag(int r);
    if (r == MCR || r == PCR) return "R6,R8";
    return "R6,R7";
  endfunction

  task automatic check(string tag, logic [23:0] act, logic [23:0] exp);
    compared++;
    if (act !== exp) begin
      mismatched++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // one clock: compare, drive, advance model; called at negedge
  task automatic cyc(bit v, int t, int c, bit ci, bit ni, bit ef, int lvl, bit seg, bit ext);
    bit congEff; int n;
    check(expTag, {outValid, outType, outConn, outCi, outNi, outEfci, outRate}, expVec);
    check("R5", 24'(inReady), 24'(!mPend));
    inValid = v; inType = 2'(t); inConn = CW'(c); inCi = ci; inNi = ni; inEfci = ef;
    abrLevel = LW'(lvl); segEnd = seg; extCong = ext;
    congEff = mCong | ext;
    expVec = '0; expTag = "R9";
    if (mPend) begin
      expVec = pack(1, mPType, mPConn, mPCi, mPNi, 0, (mPType == 1) ? mCcr[mPConn] : 0);
      expTag = (mPType == 2) ? "R4,R5" : rateTag(mCcr[mPConn]);
      mPend = 0;
    end else if (v) begin
      if (t == 0) begin
        expVec = pack(1, 0, c, 0, 0, seg ? 1'b0 : ef, 0);
        expTag = seg ? "R6" : "R3";
        if (seg) begin
          mCnt[c]++;
          if (mCnt[c] == NRM) begin
            mCnt[c] = 0; mPend = 1; mPType = 1; mPConn = c; mPCi = 0; mPNi = 0;
          end
        end
      end else if (t == 1 || t == 2) begin
        if (!seg) begin
          expVec = pack(1, t, c, ci | congEff, ni, 0, 0);
          expTag = congEff ? "R2,R3" : "R3";
        end else if (t == 1) begin
          mPend = 1; mPType = 2; mPConn = c; mPCi = ci | congEff; mPNi = ni;
          expTag = "R4";
        end else begin
          n = mCcr[c];
          if (ci) n = n - (n >> RDF);
          else if (!ni) n = n + (PCR >> RIF);
          if (n > PCR) n = PCR;
          if (n < MCR) n = MCR;
          mCcr[c] = n;
          expTag = "R7";
        end
      end
    end
    if (lvl > HI) mCong = 1;
    else if (lvl < LO) mCong = 0;
    @(negedge clk);
  endtask

  task automatic idle(int n, bit seg);
    for (int i = 0; i < n; i++) cyc(0, 3, 3, 1, 1, 1, 20, seg, 0);
  endtask

  initial begin
    #(200000 * 5);
    if (!finished) begin
      mismatched++; compared++;
      $display("FAIL watchdog expired");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
      $finish;
    end
  end

  initial begin
    modelReset();
    repeat (3) @(negedge clk);
    check("R1", {outValid, inReady}, 2'b01);
    rstN = 1'b1;
    @(negedge clk);

    // R3: transit pass-through of all types, no congestion
    cyc(1, 0, 1, 0, 0, 1, 20, 0, 0);
    cyc(1, 1, 2, 0, 1, 0, 20, 0, 0);
    cyc(1, 2, 3, 1, 0, 0, 20, 0, 0);
    cyc(1, 0, 0, 1, 1, 0, 20, 0, 0);
    // R2: hysteresis sweep with forward RM probes
    cyc(1, 1, 0, 0, 0, 0, 47, 0, 0);
    cyc(1, 1, 0, 0, 0, 0, 49, 0, 0);
    cyc(1, 1, 1, 0, 0, 0, 30, 0, 0);
    cyc(1, 2, 1, 0, 0, 0, 16, 0, 0);
    cyc(1, 1, 2, 0, 0, 0, 15, 0, 0);
    cyc(1, 2, 2, 0, 0, 0, 15, 0, 0);
    cyc(1, 1, 3, 0, 0, 0, 15, 0, 1);
    cyc(1, 1, 3, 0, 0, 0, 15, 0, 0);
    // R9: reserved and invalid inputs
    cyc(1, 3, 1, 1, 1, 1, 20, 0, 0);
    cyc(1, 3, 2, 1, 1, 1, 20, 1, 0);
    idle(3, 1);

    // R6: data on conn 1 reaches NRM, forward RM at initial rate (R1)
    for (int i = 0; i < NRM; i++) cyc(1, 0, 1, 0, 0, 1, 20, 1, 0);
    idle(2, 1);
    // R4: turnaround with and without congestion, offered cells during stall (R5)
    cyc(1, 1, 2, 0, 1, 0, 20, 1, 0);
    cyc(1, 0, 2, 0, 0, 1, 20, 1, 0);
    cyc(1, 0, 2, 0, 0, 1, 60, 1, 0);
    cyc(1, 1, 3, 0, 0, 0, 60, 1, 0);
    idle(3, 1);

    // R7/R8: drive conn 0 to minimum, hold, then to peak
    for (int i = 0; i < 16; i++) begin
      cyc(1, 2, 0, 1, 0, 0, 20, 1, 0);
      if (i % 4 == 3) for (int k = 0; k < NRM; k++) cyc(1, 0, 0, 0, 0, 0, 20, 1, 0);
    end
    idle(2, 1);
    for (int i = 0; i < 3; i++) cyc(1, 2, 0, 0, 1, 0, 20, 1, 0);
    for (int k = 0; k < NRM; k++) cyc(1, 0, 0, 0, 0, 0, 20, 1, 0);
    idle(2, 1);
    for (int i = 0; i < 34; i++) begin
      cyc(1, 2, 0, 0, 0, 0, 20, 1, 0);
      if (i % 8 == 7) for (int k = 0; k < NRM; k++) cyc(1, 0, 0, 0, 0, 0, 20, 1, 0);
    end
    for (int k = 0; k < NRM; k++) cyc(1, 0, 0, 0, 0, 0, 20, 1, 0);
    idle(2, 1);

    // mixed traffic with mode and level changes
    for (int i = 0; i < 4000; i++) begin
      cyc(($urandom % 8) != 0, $urandom % 4, $urandom % NC, $urandom % 2,
          $urandom % 2, $urandom % 2, $urandom % 64, (i / 250) % 2,
          ($urandom % 8) == 0);
    end
    idle(3, 0);

    finished = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", compared, mismatched);
    $finish;
  end

endmodule